// File: doc/BRIEF.md
# Downstream Read Request Scheduler

This block sits between a packet link and a parallel master bus. Non-posted read requests arrive from the link, each with a tag, an address and a byte length, and are held in a small request pool. The sender keeps a credit count and sends only while it holds credits. The block therefore never pushes back. It hands one credit back each time a request leaves the pool for the bus.

Before a read can go out on the bus, one slot of a pool of 128-byte read completion buffers must be reserved for it. When no slot is free, the pending requests wait. The requests that wait in the pool are chosen in rotating order. Only one bus transaction is in flight at a time. The bus side answers each issued read either with completion data or with a split response. A split keeps its slot reserved until the split completion is reported. A slot becomes free again only when the upstream side reports that the slot's data has been fully forwarded.

Top module: `rdReqSched`

## Requirements
- R1: During reset and in the first cycle after it, `issValid` and `creditRet` are 0. All completion slots are free and the request pool is empty.
- R2: A request sampled with `reqValid` is written into the lowest-numbered empty pool entry, with its tag and address unchanged. The sender never presents a request while all `QDEPTH` entries are occupied.
- R3: `creditRet` is high for exactly one cycle for each request taken out of the pool. That cycle is the first cycle in which the request is shown on the issue port.
- R4: A request is issued only when at least one completion slot is free. The request receives the lowest-numbered free slot on `issSlot`, and that slot becomes reserved. With no free slot, pending requests stay in the pool.
- R5: Among the occupied pool entries, the next request issued is the first occupied entry after the most recently issued entry, counting upward and wrapping. The first search after reset starts at entry 0.
- R6: Once raised, `issValid` and the issue fields hold until `issAccept` is sampled high. No new issue starts until `rspValid` has been sampled for the accepted read.
- R7: When `rspValid` is sampled with `rspSplit`=1, the slot stays reserved and cannot be released. A later `cmplValid` naming that slot marks its data ready. A `cmplValid` naming a slot that is not waiting for a split completion has no effect.
- R8: `rspValid` with `rspSplit`=0 marks the slot's data ready. `freeValid` releases the slot named by `freeSlot` only when that slot's data is ready. A `freeValid` naming a free, in-flight or split-waiting slot is ignored.
- R9: A requested length greater than 128 bytes is issued as exactly 128. Lengths of 128 or less are issued unchanged.
- R10: When the block is idle and a slot is free, a request sampled at one clock edge appears on the issue port after the following edge, a latency of two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present from the link |
| reqTag | input | TAG_W | Request tag |
| reqAddr | input | ADDR_W | Request address |
| reqLen | input | LEN_W | Request length in bytes |
| creditRet | output | 1 | One credit returned to the sender |
| issValid | output | 1 | Read offered to the bus master |
| issAccept | input | 1 | Bus master takes the offered read |
| issTag | output | TAG_W | Tag of the offered read |
| issAddr | output | ADDR_W | Address of the offered read |
| issLen | output | LEN_W | Length of the offered read, limited to one slot |
| issSlot | output | SIDX | Completion slot reserved for the offered read |
| rspValid | input | 1 | Bus transaction of the accepted read ended |
| rspSplit | input | 1 | The ended transaction was a split response |
| cmplValid | input | 1 | Split completion received |
| cmplSlot | input | SIDX | Slot of the split completion |
| freeValid | input | 1 | Slot data fully forwarded upstream |
| freeSlot | input | SIDX | Slot to release |

## Verification
Every output is registered. A request sampled at one edge can therefore reach the issue port and the credit output only after the next edge, two cycles after it was driven (R10). A response, split completion or release sampled at an edge can change the next issue decision no earlier than the edge after that. The bench keeps a behavioural model that applies exactly these edge-by-edge rules to the same inputs. It compares every output against the model at each falling edge, after all registers have settled. Directed phases fill the pool, use up all the slots, hold slots in split, send releases that must be ignored, and send lengths above one slot. In each phase the cycle-by-cycle comparison confirms when each issue and credit pulse happens.

// File: rtl/rdReqSchedPkg.sv
package rdReqSchedPkg;
  typedef enum logic [1:0] {
    SLOT_FREE  = 2'd0,
    SLOT_BUSY  = 2'd1,
    SLOT_SPLIT = 2'd2,
    SLOT_READY = 2'd3
  } slotState_e;

  typedef struct packed {
    logic push;
    logic load;
  } dpStrobe_t;
endpackage

// File: rtl/rdReqSchedData.sv
module rdReqSchedData
  import rdReqSchedPkg::*;
#(
  parameter int QDEPTH     = 4,
  parameter int TAG_W      = 5,
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 8,
  parameter int SLOT_BYTES = 128,
  localparam int QIDX = (QDEPTH > 1) ? $clog2(QDEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [QIDX-1:0]   pushIdx,
  input  logic [QIDX-1:0]   loadIdx,
  input  logic [TAG_W-1:0]  reqTag,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  output logic [TAG_W-1:0]  issTag,
  output logic [ADDR_W-1:0] issAddr,
  output logic [LEN_W-1:0]  issLen
);
  localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(SLOT_BYTES);

  logic [TAG_W-1:0]  tagMem  [QDEPTH];
  logic [ADDR_W-1:0] addrMem [QDEPTH];
  logic [LEN_W-1:0]  lenMem  [QDEPTH];
  logic [LEN_W-1:0]  lenClip;

  assign lenClip = (reqLen > MAX_LEN) ? MAX_LEN : reqLen;

  always_ff @(posedge clk) begin
    if (strb.push) begin
      tagMem[pushIdx]  <= reqTag;
      addrMem[pushIdx] <= reqAddr;
      lenMem[pushIdx]  <= lenClip;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      issTag  <= '0;
      issAddr <= '0;
      issLen  <= '0;
    end else if (strb.load) begin
      issTag  <= tagMem[loadIdx];
      issAddr <= addrMem[loadIdx];
      issLen  <= lenMem[loadIdx];
    end
  end

  // R9: an issued length never exceeds one completion slot
  p_len_clip_r9: assert property (@(posedge clk) disable iff (!rstN)
    issLen <= MAX_LEN);
endmodule

// File: rtl/rdReqSchedCtrl.sv
module rdReqSchedCtrl
  import rdReqSchedPkg::*;
#(
  parameter int QDEPTH = 4,
  parameter int NSLOT  = 4,
  localparam int QIDX = (QDEPTH > 1) ? $clog2(QDEPTH) : 1,
  localparam int SIDX = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            reqValid,
  input  logic            issAccept,
  input  logic            rspValid,
  input  logic            rspSplit,
  input  logic            cmplValid,
  input  logic [SIDX-1:0] cmplSlot,
  input  logic            freeValid,
  input  logic [SIDX-1:0] freeSlot,
  output dpStrobe_t       strb,
  output logic [QIDX-1:0] pushIdx,
  output logic [QIDX-1:0] loadIdx,
  output logic            issValid,
  output logic [SIDX-1:0] issSlot,
  output logic            creditRet
);
  logic [QDEPTH-1:0] entValid, entNext;
  logic [QIDX-1:0]   rrPtr;
  slotState_e        slotSt   [NSLOT];
  slotState_e        slotNext [NSLOT];
  logic              issValidQ, waitRsp, creditQ;
  logic [SIDX-1:0]   issSlotQ;

  logic              pickFound, slotFound, canPick;
  logic [QIDX-1:0]   pickEnt, freeEnt;
  logic [SIDX-1:0]   freeSlotIdx;

  // lowest empty pool entry
  always_comb begin
    freeEnt = '0;
    for (int i = QDEPTH - 1; i >= 0; i--)
      if (!entValid[i]) freeEnt = QIDX'(i);
  end

  // lowest free completion slot
  always_comb begin
    slotFound   = 1'b0;
    freeSlotIdx = '0;
    for (int s = NSLOT - 1; s >= 0; s--)
      if (slotSt[s] == SLOT_FREE) begin
        slotFound   = 1'b1;
        freeSlotIdx = SIDX'(s);
      end
  end

  // rotating search starting one past the last issued entry
  always_comb begin
    int j;
    pickFound = 1'b0;
    pickEnt   = '0;
    for (int k = 1; k <= QDEPTH; k++) begin
      j = int'(rrPtr) + k;
      if (j >= QDEPTH) j = j - QDEPTH;
      if (!pickFound && entValid[j]) begin
        pickFound = 1'b1;
        pickEnt   = QIDX'(j);
      end
    end
  end

  assign canPick = !issValidQ && !waitRsp && pickFound && slotFound;

  always_comb begin
    entNext = entValid;
    if (canPick)  entNext[pickEnt] = 1'b0;
    if (reqValid) entNext[freeEnt] = 1'b1;
  end

  always_comb begin
    for (int s = 0; s < NSLOT; s++) begin
      slotNext[s] = slotSt[s];
      if (canPick && freeSlotIdx == SIDX'(s))
        slotNext[s] = SLOT_BUSY;
      if (waitRsp && rspValid && issSlotQ == SIDX'(s) && slotSt[s] == SLOT_BUSY)
        slotNext[s] = rspSplit ? SLOT_SPLIT : SLOT_READY;
      if (cmplValid && cmplSlot == SIDX'(s) && slotSt[s] == SLOT_SPLIT)
        slotNext[s] = SLOT_READY;
      if (freeValid && freeSlot == SIDX'(s) && slotSt[s] == SLOT_READY)
        slotNext[s] = SLOT_FREE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      entValid  <= '0;
      rrPtr     <= QIDX'(QDEPTH - 1);
      issValidQ <= 1'b0;
      issSlotQ  <= '0;
      waitRsp   <= 1'b0;
      creditQ   <= 1'b0;
      for (int s = 0; s < NSLOT; s++) slotSt[s] <= SLOT_FREE;
    end else begin
      entValid <= entNext;
      creditQ  <= canPick;
      for (int s = 0; s < NSLOT; s++) slotSt[s] <= slotNext[s];
      if (canPick) begin
        issValidQ <= 1'b1;
        issSlotQ  <= freeSlotIdx;
        rrPtr     <= pickEnt;
      end else if (issValidQ && issAccept) begin
        issValidQ <= 1'b0;
        waitRsp   <= 1'b1;
      end else if (waitRsp && rspValid) begin
        waitRsp <= 1'b0;
      end
    end
  end

  assign strb.push = reqValid;
  assign strb.load = canPick;
  assign pushIdx   = freeEnt;
  assign loadIdx   = pickEnt;
  assign issValid  = issValidQ;
  assign issSlot   = issSlotQ;
  assign creditRet = creditQ;

  // R2: credits keep the sender off a full pool
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> !(&entValid));

  // R6: an offered read holds until taken
  p_hold_offer_r6: assert property (@(posedge clk) disable iff (!rstN)
    issValidQ && !issAccept |=> issValidQ && $stable(issSlotQ));

  // R6: nothing is offered while a bus transaction is open
  p_single_bus_r6: assert property (@(posedge clk) disable iff (!rstN)
    waitRsp |-> !issValidQ);

  // R4: a newly offered read owns a reserved slot
  p_slot_reserved_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(issValidQ) |-> slotSt[issSlotQ] == SLOT_BUSY);

  // R8: a release naming a free slot leaves it free unless it is picked
  p_stray_free_r8: assert property (@(posedge clk) disable iff (!rstN)
    freeValid && slotSt[freeSlot] == SLOT_FREE && !canPick
      |=> slotSt[$past(freeSlot)] == SLOT_FREE);

  for (genvar g = 0; g < NSLOT; g++) begin : g_splitChk
    // R7: a split-waiting slot leaves that state only through its completion
    p_split_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
      slotSt[g] == SLOT_SPLIT && !(cmplValid && cmplSlot == SIDX'(g))
        |=> slotSt[g] == SLOT_SPLIT);
  end
endmodule

// File: rtl/rdReqSched.sv
module rdReqSched
  import rdReqSchedPkg::*;
#(
  parameter int QDEPTH     = 4,
  parameter int NSLOT      = 4,
  parameter int TAG_W      = 5,
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 8,
  parameter int SLOT_BYTES = 128,
  localparam int QIDX = (QDEPTH > 1) ? $clog2(QDEPTH) : 1,
  localparam int SIDX = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [TAG_W-1:0]  reqTag,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  output logic              creditRet,
  output logic              issValid,
  input  logic              issAccept,
  output logic [TAG_W-1:0]  issTag,
  output logic [ADDR_W-1:0] issAddr,
  output logic [LEN_W-1:0]  issLen,
  output logic [SIDX-1:0]   issSlot,
  input  logic              rspValid,
  input  logic              rspSplit,
  input  logic              cmplValid,
  input  logic [SIDX-1:0]   cmplSlot,
  input  logic              freeValid,
  input  logic [SIDX-1:0]   freeSlot
);
  dpStrobe_t       strb;
  logic [QIDX-1:0] pushIdx, loadIdx;

  rdReqSchedCtrl #(.QDEPTH(QDEPTH), .NSLOT(NSLOT)) i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .issAccept(issAccept),
    .rspValid(rspValid), .rspSplit(rspSplit), .cmplValid(cmplValid),
    .cmplSlot(cmplSlot), .freeValid(freeValid), .freeSlot(freeSlot),
    .strb(strb), .pushIdx(pushIdx), .loadIdx(loadIdx),
    .issValid(issValid), .issSlot(issSlot), .creditRet(creditRet)
  );

  rdReqSchedData #(
    .QDEPTH(QDEPTH), .TAG_W(TAG_W), .ADDR_W(ADDR_W),
    .LEN_W(LEN_W), .SLOT_BYTES(SLOT_BYTES)
  ) i_data (
    .clk(clk), .rstN(rstN), .strb(strb), .pushIdx(pushIdx), .loadIdx(loadIdx),
    .reqTag(reqTag), .reqAddr(reqAddr), .reqLen(reqLen),
    .issTag(issTag), .issAddr(issAddr), .issLen(issLen)
  );
endmodule

// File: tb/test_rdReqSched.sv
module test_rdReqSched;
  localparam int CLK_PERIOD = 10;
  localparam int QDEPTH = 4, NSLOT = 4, TAG_W = 5, ADDR_W = 32, LEN_W = 8;
  localparam int SLOT_BYTES = 128, SIDX = 2;

  logic clk, rstN;
  logic reqValid;
  logic [TAG_W-1:0] reqTag;
  logic [ADDR_W-1:0] reqAddr;
  logic [LEN_W-1:0] reqLen;
  logic creditRet, issValid, issAccept;
  logic [TAG_W-1:0] issTag;
  logic [ADDR_W-1:0] issAddr;
  logic [LEN_W-1:0] issLen;
  logic [SIDX-1:0] issSlot;
  logic rspValid, rspSplit, cmplValid, freeValid;
  logic [SIDX-1:0] cmplSlot, freeSlot;

  rdReqSched #(.QDEPTH(QDEPTH), .NSLOT(NSLOT), .TAG_W(TAG_W), .ADDR_W(ADDR_W),
               .LEN_W(LEN_W), .SLOT_BYTES(SLOT_BYTES)) i_rdReqSched (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqTag(reqTag),
    .reqAddr(reqAddr), .reqLen(reqLen), .creditRet(creditRet),
    .issValid(issValid), .issAccept(issAccept), .issTag(issTag),
    .issAddr(issAddr), .issLen(issLen), .issSlot(issSlot),
    .rspValid(rspValid), .rspSplit(rspSplit), .cmplValid(cmplValid),
    .cmplSlot(cmplSlot), .freeValid(freeValid), .freeSlot(freeSlot)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  typedef struct {
    logic [TAG_W-1:0] t;
    logic [ADDR_W-1:0] a;
    logic [LEN_W-1:0] l;
  } req_t;

  int nChecks = 0, nErr = 0, cycle = 0;
  string phase = "R1 reset";
  bit finished = 0;

  // behavioural reference: 0 free, 1 in flight, 2 split wait, 3 data ready
  bit mEnt [QDEPTH];
  req_t mReq [QDEPTH];
  int mSlot [NSLOT];
  int mRr, mIssSlot;
  bit mIss, mWait, mCred;
  req_t mIssReq;

  // bench agents
  req_t sendQ [$];
  int readyQ [$], splitQ [$], manFreeQ [$], manCmplQ [$];
  int credit = QDEPTH;
  int accDly = 0, rspDly = 0, freeDly = 0;
  bit splitAll = 0, autoFree = 1;
  int busState = 0, accCnt = 0, rspCnt = 0, freeCnt = 0, curSlot = 0;
  bit watchLat = 0, latDone = 0;
  int tReq = 0;

  task automatic chk(string what, longint act, longint exp);
    nChecks++;
    if (act != exp) begin
      nErr++;
      $display("FAIL [%s] %s: actual %0h expected %0h", phase, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    bit preEnt [QDEPTH];
    int preSlot [NSLOT];
    bit preIss, preWait;
    int pe, ps, fe, j;
    if (!rstN) begin
      for (int i = 0; i < QDEPTH; i++) mEnt[i] = 0;
      for (int s = 0; s < NSLOT; s++) mSlot[s] = 0;
      mRr = QDEPTH - 1; mIss = 0; mWait = 0; mCred = 0; mIssSlot = 0;
    end else begin
      preEnt = mEnt; preSlot = mSlot; preIss = mIss; preWait = mWait;
      pe = -1; ps = -1; fe = -1;
      for (int s = NSLOT - 1; s >= 0; s--) if (preSlot[s] == 0) ps = s;
      for (int i = QDEPTH - 1; i >= 0; i--) if (!preEnt[i]) fe = i;
      for (int k = 1; k <= QDEPTH; k++) begin
        j = (mRr + k) % QDEPTH;
        if (pe < 0 && preEnt[j]) pe = j;
      end
      mCred = 0;
      if (preIss && issAccept) begin mIss = 0; mWait = 1; end
      if (preWait && rspValid) begin
        mWait = 0;
        mSlot[mIssSlot] = rspSplit ? 2 : 3;
      end
      if (cmplValid && preSlot[cmplSlot] == 2) mSlot[cmplSlot] = 3;
      if (freeValid && preSlot[freeSlot] == 3) mSlot[freeSlot] = 0;
      if (!preIss && !preWait && pe >= 0 && ps >= 0) begin
        mIss = 1; mIssReq = mReq[pe]; mEnt[pe] = 0;
        mSlot[ps] = 1; mIssSlot = ps; mRr = pe; mCred = 1;
      end
      if (reqValid && fe >= 0) begin
        mEnt[fe] = 1;
        mReq[fe].t = reqTag;
        mReq[fe].a = reqAddr;
        mReq[fe].l = (reqLen > LEN_W'(SLOT_BYTES)) ? LEN_W'(SLOT_BYTES) : reqLen;
      end
    end
  end

  always @(negedge clk) begin
    req_t r;
    cycle++;
    if (rstN && !finished) begin
      chk("creditRet R3", creditRet, mCred);
      chk("issValid R6", issValid, mIss);
      if (mIss) begin
        chk("issTag R5", issTag, mIssReq.t);
        chk("issAddr R2", issAddr, mIssReq.a);
        chk("issLen R9", issLen, mIssReq.l);
        chk("issSlot R4", issSlot, mIssSlot);
      end
      if (watchLat && !latDone && issValid) begin
        latDone = 1;
        chk("R10 request-to-issue cycles", cycle - tReq, 2);
      end
    end
    if (rstN) begin
      if (creditRet) credit++;
      reqValid = 0;
      if (sendQ.size() > 0 && credit > 0) begin
        r = sendQ.pop_front();
        credit--;
        reqValid = 1; reqTag = r.t; reqAddr = r.a; reqLen = r.l;
        tReq = cycle;
      end
      freeValid = 0;
      if (manFreeQ.size() > 0) begin
        freeValid = 1; freeSlot = SIDX'(manFreeQ.pop_front());
      end else if (autoFree && readyQ.size() > 0) begin
        if (freeCnt >= freeDly) begin
          freeValid = 1; freeSlot = SIDX'(readyQ.pop_front()); freeCnt = 0;
        end else freeCnt++;
      end
      cmplValid = 0;
      if (manCmplQ.size() > 0) begin
        cmplValid = 1; cmplSlot = SIDX'(manCmplQ[0]);
        readyQ.push_back(manCmplQ.pop_front());
      end
      issAccept = 0; rspValid = 0;
      if (busState == 0 && issValid) begin
        if (accCnt >= accDly) begin
          issAccept = 1; curSlot = int'(issSlot); busState = 1; rspCnt = 0;
        end else accCnt++;
      end else if (busState == 1) begin
        if (rspCnt >= rspDly) begin
          rspValid = 1; rspSplit = splitAll; busState = 0; accCnt = 0;
          if (splitAll) splitQ.push_back(curSlot); else readyQ.push_back(curSlot);
        end else rspCnt++;
      end
    end
  end

  function automatic bit modelIdle();
    bit idle;
    idle = sendQ.size() == 0 && !reqValid && !mIss && !mWait && busState == 0 &&
           readyQ.size() == 0 && splitQ.size() == 0 && manFreeQ.size() == 0 &&
           manCmplQ.size() == 0;
    for (int i = 0; i < QDEPTH; i++) if (mEnt[i]) idle = 0;
    for (int s = 0; s < NSLOT; s++) if (mSlot[s] != 0) idle = 0;
    return idle;
  endfunction

  task automatic waitIdle();
    repeat (3) @(negedge clk);
    while (!modelIdle()) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic sendReq(int t, int a, int l);
    req_t r;
    r.t = TAG_W'(t); r.a = ADDR_W'(a); r.l = LEN_W'(l);
    sendQ.push_back(r);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nErr++;
    $display("FAIL [%s] watchdog expired", phase);
    summary();
  end

  initial begin
    rstN = 0; reqValid = 0; reqTag = '0; reqAddr = '0; reqLen = '0;
    issAccept = 0; rspValid = 0; rspSplit = 0; cmplValid = 0; cmplSlot = '0;
    freeValid = 0; freeSlot = '0;
    repeat (3) @(negedge clk);
    chk("R1 issValid in reset", issValid, 0);
    chk("R1 creditRet in reset", creditRet, 0);
    rstN = 1;
    @(negedge clk);
    chk("R1 issValid after reset", issValid, 0);
    chk("R1 creditRet after reset", creditRet, 0);

    phase = "R10 R3 single request";
    accDly = 0; rspDly = 1; splitAll = 0; autoFree = 1; freeDly = 2;
    watchLat = 1;
    sendReq(3, 'h1000, 64);
    waitIdle();
    watchLat = 0;
    chk("R10 latency measured", latDone, 1);

    phase = "R5 R2 rotating pick";
    accDly = 4; rspDly = 2; freeDly = 1;
    for (int i = 1; i <= 10; i++) sendReq(i, i * 'h40, 64);
    waitIdle();

    phase = "R4 slot exhaustion";
    accDly = 0; rspDly = 0; autoFree = 0;
    for (int i = 11; i <= 16; i++) sendReq(i, 'h2000 + i * 4, 32);
    repeat (30) @(negedge clk);
    chk("R4 no issue with all slots held", issValid, 0);
    manFreeQ.push_back(2);
    for (int i = 0; i < readyQ.size(); i++)
      if (readyQ[i] == 2) begin readyQ.delete(i); break; end
    repeat (10) @(negedge clk);
    autoFree = 1;
    waitIdle();

    phase = "R7 split hold";
    splitAll = 1; rspDly = 1;
    for (int i = 17; i <= 21; i++) sendReq(i, 'h3000 + i * 8, 100);
    repeat (30) @(negedge clk);
    for (int s = 0; s < NSLOT; s++) manFreeQ.push_back(s);
    repeat (8) @(negedge clk);
    chk("R7 no issue while all slots split", issValid, 0);
    manCmplQ.push_back(0);
    repeat (3) @(negedge clk);
    manCmplQ.push_back(2);
    repeat (3) @(negedge clk);
    splitAll = 0;
    while (splitQ.size() > 0) begin
      manCmplQ.push_back(splitQ.pop_front());
      repeat (3) @(negedge clk);
    end
    repeat (10) @(negedge clk);
    while (splitQ.size() > 0) begin
      manCmplQ.push_back(splitQ.pop_front());
      repeat (3) @(negedge clk);
    end
    waitIdle();

    phase = "R8 stray release";
    manFreeQ.push_back(1);
    manFreeQ.push_back(3);
    repeat (3) @(negedge clk);
    accDly = 6;
    sendReq(22, 'h4000, 16);
    sendReq(23, 'h4010, 16);
    repeat (4) @(negedge clk);
    manFreeQ.push_back(0);
    manCmplQ.push_back(0);
    readyQ.pop_back();
    waitIdle();

    phase = "R9 length clip";
    accDly = 1; rspDly = 0;
    sendReq(24, 'h5000, 200);
    sendReq(25, 'h5100, 128);
    sendReq(26, 'h5200, 129);
    sendReq(27, 'h5300, 1);
    sendReq(28, 'h5400, 255);
    waitIdle();

    summary();
  end
endmodule